// File: doc/BRIEF.md
# Dual-Clock Dual-Port Synchronous RAM with Per-Port Output Latency

This block is a true two-port static RAM. Each side has its own clock, address, read/write control, write data, active-low output enable and a two-input chip select. Both sides may read or write any word in the same cycle as the other. On each rising edge of its clock, a port registers its address, controls, write data and latency mode. The array access then runs from those registers.

Each port picks its read latency at run time. With the mode input low, the port runs flow-through: read data is taken straight from the array after the registered address. With it high, an extra output register adds one cycle. In the pipelined case, a port coming back from a deselected cycle shows nothing for one selected cycle before valid data returns. The data output is meant to feed an external three-state pad. A separate drive flag says when the pad should be driven, and the data lines read zero whenever that flag is low.

Top module: `dual_clock_ram`

## Requirements
- R1: A port selected with its read/write input low (0 = write) stores the registered write data at the registered address. A later read (read/write input 1) of that address on the same port returns it.
- R2: Both ports work at the same time on any addresses. A word written by one port is read back by the other port.
- R3: Inputs are sampled on a rising edge k. With the mode input at 0 (flow-through), read data is driven between edge k and edge k+1. With the mode input at 1 (pipelined), the same read is driven between edge k+1 and edge k+2.
- R4: A port is selected only when its low-active enable is 0 and its high-active enable is 1. In any other combination the cycle writes nothing and the read it would have made drives nothing.
- R5: In pipelined mode, the cycle that follows a deselected cycle drives nothing, even when that cycle is selected. Data returns after one selected read cycle.
- R6: The output enable input is active low and acts without a clock. While it is 1 the drive flag is 0. Whenever the drive flag is 0 the data lines are all zero.
- R7: When one port writes an address while the other reads it on the same edge, the reader returns the value held before that write. The next read returns the new value.
- R8: After reset neither port drives data until a selected read has been made.
- R9: A write cycle drives nothing. This holds in flow-through mode during the write cycle, and in pipelined mode during the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset of both ports' registers |
| enLoNA | input | 1 | Port A enable, active low |
| enHiA | input | 1 | Port A enable, active high |
| rdWrA | input | 1 | Port A access type, 1 = read, 0 = write |
| pipeModeA | input | 1 | Port A latency, 0 = flow-through, 1 = pipelined |
| addrA | input | ADDR_W | Port A word address |
| dinA | input | DATA_W | Port A write data |
| oeNA | input | 1 | Port A output enable, active low |
| qA | output | DATA_W | Port A read data, zero when not driven |
| qOeA | output | 1 | Port A pad drive flag |
| enLoNB | input | 1 | Port B enable, active low |
| enHiB | input | 1 | Port B enable, active high |
| rdWrB | input | 1 | Port B access type, 1 = read, 0 = write |
| pipeModeB | input | 1 | Port B latency, 0 = flow-through, 1 = pipelined |
| addrB | input | ADDR_W | Port B word address |
| dinB | input | DATA_W | Port B write data |
| oeNB | input | 1 | Port B output enable, active low |
| qB | output | DATA_W | Port B read data, zero when not driven |
| qOeB | output | 1 | Port B pad drive flag |

## Verification
The bench targets several corner cases.

- Same-address traffic from both sides on one edge. A design that committed the write before the read would hand the reader the new word one cycle early.
- Deselect patterns with each wrong enable combination. A design that decoded the enable pair loosely would corrupt memory or drive the pad while unselected.
- Pipelined reads broken up by deselected cycles. A design without the reactivation rule would drive stale register contents in the first cycle back.
- Output-enable toggling and run-time mode changes. These expose latency errors and a registered output enable, since either would shift the drive flag by a cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  // Registered per-port strobes handed from control to datapath
  typedef struct packed {
    logic sel;   // port selected this cycle
    logic wr;    // selected write
    logic rd;    // selected read
    logic pipe;  // pipelined latency chosen
  } portStrobe_t;
endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enLoN,
  input  logic              enHi,
  input  logic              rdWr,
  input  logic              pipeMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output portStrobe_t       strobe,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dinQ
);

  logic selNow;
  assign selNow = !enLoN && enHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe <= '0;
      addrQ  <= '0;
      dinQ   <= '0;
    end else begin
      strobe.sel  <= selNow;
      strobe.wr   <= selNow && !rdWr;
      strobe.rd   <= selNow && rdWr;
      strobe.pipe <= pipeMode;
      addrQ       <= addr;
      dinQ        <= din;
    end
  end

  // R4: an unselected input pattern leaves no access behind
  assert_deselect_no_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enLoN || !enHi) |=> (!strobe.sel && !strobe.wr && !strobe.rd));

  // R1: read/write low while selected becomes a write, never a read
  assert_write_decode_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!enLoN && enHi && !rdWr) |=> (strobe.wr && !strobe.rd));

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
  import dpr_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [DATA_W-1:0] rdWord,
  input  logic              oeN,
  output logic [DATA_W-1:0] q,
  output logic              qOe
);

  logic              pipeValid;
  logic [DATA_W-1:0] pipeData;
  logic              active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeValid <= 1'b0;
      pipeData  <= '0;
    end else begin
      pipeValid <= strobe.rd;
      if (strobe.rd) pipeData <= rdWord;
    end
  end

  always_comb begin
    active = strobe.pipe ? pipeValid : strobe.rd;
    qOe    = active && !oeN;
    if (!qOe)            q = '0;
    else if (strobe.pipe) q = pipeData;
    else                 q = rdWord;
  end

  // R5: pipelined output stays off in the cycle after a deselect
  assert_pipe_reactivate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pipe && !$past(strobe.sel)) |-> !qOe);

  // R3: pipelined data is the array word of the previous cycle
  assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pipe && qOe) |-> (q == $past(rdWord)));

  // R9: no drive for a write, in either latency mode
  assert_flow_write_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pipe && strobe.wr) |-> !qOe);
  assert_pipe_write_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pipe && $past(strobe.wr)) |-> !qOe);

  // R6: a high output enable keeps the pad released
  assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!qOe && q == '0));

endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  portStrobe_t       strobeA,
  input  portStrobe_t       strobeB,
  input  logic [ADDR_W-1:0] addrQA,
  input  logic [ADDR_W-1:0] addrQB,
  input  logic [DATA_W-1:0] dinQA,
  input  logic [DATA_W-1:0] dinQB,
  input  logic              oeNA,
  input  logic              oeNB,
  output logic [DATA_W-1:0] qA,
  output logic              qOeA,
  output logic [DATA_W-1:0] qB,
  output logic              qOeB
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PORTS = 2;

  // Each bank has a single writer; a word is the XOR of both banks
  logic [DATA_W-1:0] bankA [DEPTH];
  logic [DATA_W-1:0] bankB [DEPTH];

  always_ff @(posedge clkA) begin
    if (strobeA.wr) bankA[addrQA] <= dinQA ^ bankB[addrQA];
  end

  always_ff @(posedge clkB) begin
    if (strobeB.wr) bankB[addrQB] <= dinQB ^ bankA[addrQB];
  end

  logic              clkV    [PORTS];
  portStrobe_t       strobeV [PORTS];
  logic [DATA_W-1:0] rdWordV [PORTS];
  logic              oeNV    [PORTS];
  logic [DATA_W-1:0] qV      [PORTS];
  logic              qOeV    [PORTS];

  assign clkV[0]    = clkA;
  assign clkV[1]    = clkB;
  assign strobeV[0] = strobeA;
  assign strobeV[1] = strobeB;
  assign rdWordV[0] = bankA[addrQA] ^ bankB[addrQA];
  assign rdWordV[1] = bankA[addrQB] ^ bankB[addrQB];
  assign oeNV[0]    = oeNA;
  assign oeNV[1]    = oeNB;

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_out
    dpr_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk    (clkV[gp]),
      .rstN   (rstN),
      .strobe (strobeV[gp]),
      .rdWord (rdWordV[gp]),
      .oeN    (oeNV[gp]),
      .q      (qV[gp]),
      .qOe    (qOeV[gp])
    );
  end

  assign qA   = qV[0];
  assign qOeA = qOeV[0];
  assign qB   = qV[1];
  assign qOeB = qOeV[1];

endmodule

// File: rtl/dual_clock_ram.sv
module dual_clock_ram
  import dpr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              enLoNA,
  input  logic              enHiA,
  input  logic              rdWrA,
  input  logic              pipeModeA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  input  logic              oeNA,
  output logic [DATA_W-1:0] qA,
  output logic              qOeA,
  input  logic              enLoNB,
  input  logic              enHiB,
  input  logic              rdWrB,
  input  logic              pipeModeB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  input  logic              oeNB,
  output logic [DATA_W-1:0] qB,
  output logic              qOeB
);

  portStrobe_t       strobeA, strobeB;
  logic [ADDR_W-1:0] addrQA, addrQB;
  logic [DATA_W-1:0] dinQA, dinQB;

  dpr_port_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrlA (
    .clk(clkA), .rstN(rstN), .enLoN(enLoNA), .enHi(enHiA), .rdWr(rdWrA),
    .pipeMode(pipeModeA), .addr(addrA), .din(dinA),
    .strobe(strobeA), .addrQ(addrQA), .dinQ(dinQA)
  );

  dpr_port_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrlB (
    .clk(clkB), .rstN(rstN), .enLoN(enLoNB), .enHi(enHiB), .rdWr(rdWrB),
    .pipeMode(pipeModeB), .addr(addrB), .din(dinB),
    .strobe(strobeB), .addrQ(addrQB), .dinQ(dinQB)
  );

  dpr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strobeA(strobeA), .strobeB(strobeB),
    .addrQA(addrQA), .addrQB(addrQB), .dinQA(dinQA), .dinQB(dinQB),
    .oeNA(oeNA), .oeNB(oeNB),
    .qA(qA), .qOeA(qOeA), .qB(qB), .qOeB(qOeB)
  );

endmodule

// File: tb/dual_clock_ram_bench.sv
module dual_clock_ram_bench;
  localparam int DW = 9;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          enLoN [2];
  logic          enHi  [2];
  logic          rdWr  [2];
  logic          pipeM [2];
  logic          oeN   [2];
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] din   [2];
  logic [DW-1:0] qA, qB;
  logic          qOeA, qOeB;

  dual_clock_ram #(.DATA_W(DW), .ADDR_W(AW)) u_dual_clock_ram (
    .clkA(clk), .clkB(clk), .rstN(rstN),
    .enLoNA(enLoN[0]), .enHiA(enHi[0]), .rdWrA(rdWr[0]), .pipeModeA(pipeM[0]),
    .addrA(addr[0]), .dinA(din[0]), .oeNA(oeN[0]), .qA(qA), .qOeA(qOeA),
    .enLoNB(enLoN[1]), .enHiB(enHi[1]), .rdWrB(rdWr[1]), .pipeModeB(pipeM[1]),
    .addrB(addr[1]), .dinB(din[1]), .oeNB(oeN[1]), .qB(qB), .qOeB(qOeB)
  );

  // Behavioural reference
  logic [DW-1:0] refMem [DEPTH];
  logic          curSR [2], prevSR [2], curWe [2], curMode [2];
  logic [AW-1:0] curAddr [2];
  logic [DW-1:0] curDin [2], curVal [2], prevVal [2];

  int compared = 0;
  int mismatched = 0;
  string tag = "R8";

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 37 + 5) % (1 << DW));
  endfunction

  task automatic modelEdge();
    for (int p = 0; p < 2; p++) begin
      prevSR[p]  = curSR[p];
      prevVal[p] = curVal[p];
    end
    for (int p = 0; p < 2; p++)
      if (curWe[p]) refMem[curAddr[p]] = curDin[p];
    for (int p = 0; p < 2; p++) begin
      logic s;
      s = !enLoN[p] && enHi[p];
      curSR[p]   = s && rdWr[p];
      curWe[p]   = s && !rdWr[p];
      curMode[p] = pipeM[p];
      curAddr[p] = addr[p];
      curDin[p]  = din[p];
      curVal[p]  = refMem[addr[p]];
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      logic          act, expOe;
      logic [DW-1:0] expQ, gotQ;
      logic          gotOe;
      act   = curMode[p] ? prevSR[p] : curSR[p];
      expOe = act && !oeN[p];
      expQ  = expOe ? (curMode[p] ? prevVal[p] : curVal[p]) : '0;
      gotQ  = (p == 0) ? qA : qB;
      gotOe = (p == 0) ? qOeA : qOeB;
      compared++;
      if (gotOe !== expOe || gotQ !== expQ) begin
        mismatched++;
        $display("FAIL %s port %0d: actual oe=%0b q=%h expected oe=%0b q=%h",
                 tag, p, gotOe, gotQ, expOe, expQ);
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare();
  endtask

  task automatic setp(int p, bit sel, bit rd, int a, int d, bit mode, bit oe);
    enLoN[p] = !sel;
    enHi[p]  = sel;
    rdWr[p]  = rd;
    addr[p]  = AW'(a);
    din[p]   = DW'(d);
    pipeM[p] = mode;
    oeN[p]   = oe;
  endtask

  task automatic idle(int p);
    setp(p, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    for (int p = 0; p < 2; p++) begin
      curSR[p] = 0; prevSR[p] = 0; curWe[p] = 0; curMode[p] = 0;
      curAddr[p] = '0; curDin[p] = '0; curVal[p] = '0; prevVal[p] = '0;
      idle(p);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset state, nothing driven while idle with outputs enabled
    tag = "R8";
    compare();
    repeat (3) cycle();

    // R1: fill the whole array through port A
    tag = "R1";
    for (int i = 0; i < DEPTH; i++) begin
      setp(0, 1, 0, i, pat(i), 0, 0);
      cycle();
    end
    for (int i = 0; i < 16; i++) begin
      setp(0, 1, 1, i, 0, 0, 0);
      cycle();
    end
    idle(0);
    cycle();

    // R3: pipelined reads on B while A reads flow-through
    tag = "R3";
    for (int i = 0; i < 24; i++) begin
      setp(0, 1, 1, 60 + i, 0, 0, 0);
      setp(1, 1, 1, 20 + i, 0, 1, 0);
      cycle();
    end
    idle(0); idle(1);
    cycle(); cycle();

    // R2: B writes, A reads back two cycles behind
    tag = "R2";
    for (int j = 0; j < 20; j++) begin
      if (j < 16) setp(1, 1, 0, 100 + j, 9'h155 ^ j, 0, 0); else idle(1);
      if (j >= 2) setp(0, 1, 1, 100 + j - 2, 0, 0, 0); else idle(0);
      cycle();
    end
    idle(0); idle(1);
    cycle();

    // R7: write on A and read on B of one address on the same edge
    tag = "R7";
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < 8; j++) begin
        setp(0, 1, 0, 150 + j, 9'h0aa + j + m * 16, 0, 0);
        setp(1, 1, 1, 150 + j, 0, m[0], 0);
        cycle();
        idle(0);
        setp(1, 1, 1, 150 + j, 0, m[0], 0);
        cycle();
      end
    end
    idle(0); idle(1);
    cycle(); cycle();

    // R4: every deselecting enable combination, for writes and reads
    tag = "R4";
    for (int c = 0; c < 3; c++) begin
      setp(0, 0, 0, 5, 9'h1ff, 0, 0);
      enLoN[0] = (c != 1);
      enHi[0]  = (c == 0);
      cycle();
      setp(0, 0, 1, 5, 0, c == 2, 0);
      enLoN[0] = (c != 1);
      enHi[0]  = (c == 0);
      cycle();
      setp(0, 1, 1, 5, 0, 0, 0);
      cycle();
    end
    idle(0);
    cycle();

    // R5: pipelined reads broken by deselected cycles
    tag = "R5";
    for (int j = 0; j < 20; j++) begin
      bit s;
      s = (j % 3 != 0) || (j % 7 == 0);
      setp(1, s, 1, 30 + j, 0, 1, 0);
      cycle();
    end
    idle(1);
    cycle(); cycle();

    // R6: output enable toggled while reading in both modes
    tag = "R6";
    for (int j = 0; j < 16; j++) begin
      setp(0, 1, 1, 200 + j, 0, 0, j[0]);
      setp(1, 1, 1, 210 + j, 0, 1, j[1]);
      cycle();
    end
    idle(0); idle(1);
    cycle(); cycle();

    // R9: interleaved writes and reads in pipelined and flow-through modes
    tag = "R9";
    for (int j = 0; j < 24; j++) begin
      bit w;
      w = (j % 3 != 1);
      setp(0, 1, !w, 40 + (j % 5), 9'h0f0 + j, 1, 0);
      setp(1, 1, j[0], 80 + (j % 4), 9'h033 + j, 0, 0);
      cycle();
    end
    idle(0); idle(1);
    cycle(); cycle();

    // R2: mixed random traffic with run-time mode changes
    tag = "R2";
    for (int j = 0; j < 3000; j++) begin
      for (int p = 0; p < 2; p++) begin
        int sw;
        sw = $urandom_range(0, 9);
        setp(p, 1, $urandom_range(0, 1) == 1, $urandom_range(0, 15),
             $urandom_range(0, (1 << DW) - 1), $urandom_range(0, 3) == 0,
             $urandom_range(0, 5) == 0);
        pipeM[p] = (j / 40 + p) % 2 == 1 ? (sw != 0) : (sw == 0);
        if (sw == 1) enLoN[p] = 1'b1;
        if (sw == 2) enHi[p] = 1'b0;
      end
      if (!enLoN[0] && enHi[0] && !rdWr[0] && !enLoN[1] && enHi[1] && !rdWr[1]
          && addr[0] == addr[1]) rdWr[1] = 1'b1;
      cycle();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule